// File: doc/BRIEF.md
# Card-Slot Status and Board Identity Registers

This block is a small register file for a card-slot interface. It brings two board-level lines into the clock domain: a write-protect switch level and a card-insert indication. The write-protect level is shown live in a status register. A card insertion is held in a sticky flag in the same register, and that flag drives an interrupt.

Software clears the sticky flag by writing a one to its bit position. Two further words return fixed identification and decode values. A flash-programming word accepts writes but has no effect. The bus is word addressed, with a combinational read path and a single-cycle write strobe.

Top module: `card_id_regs`

## Requirements
- R1: Word address 0 reads the constant 0x41034003.
- R2: Word address 3 reads the constant 0x11.
- R3: Word address 1 reads 0, and writes to it change no readable state.
- R4: Bit 0 of word address 2 equals the write-protect input level as it stood two clock edges earlier, through a two-flop synchroniser. Writes do not change this bit.
- R5: Bit 3 of word address 2 (the insert flag) is set on the edge after the synchronised insert input is seen high. It stays set after that input falls.
- R6: A write to word address 2 with bit 3 of the data set clears the insert flag on that edge. A write with bit 3 clear leaves the flag unchanged.
- R7: irq_out always equals the insert flag.
- R8: When the synchronised insert input is high in the same cycle as a clearing write, the flag stays set.
- R9: While reset is asserted, the insert flag and irq_out are 0 and the synchronisers are cleared.
- R10: Word addresses other than 0 to 3 read 0 and ignore writes, and bits of word 2 other than 0 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq_out | output | 1 | Card-insert interrupt |
| wp_in | input | 1 | Write-protect switch level, asynchronous |
| ins_in | input | 1 | Card-insert indication, asynchronous |

## Verification
If the insert flag holds a wrong value, irq_out shows it in the same cycle, and so does bit 3 of word 2. A wrong synchroniser depth or a missing stage shifts both status bits by a whole cycle against the model. That shift shows on the first input toggle. The model is compared on every clock with random inputs, writes and addresses. Directed sequences add the corner cases: a sticky hold after the input falls, a clear that lands in the same cycle as a set, and writes to read-only bits.

// File: rtl/card_id_regs.sv
module card_id_regs #(
  parameter int          ADDR_W      = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] ID_WORD     = 32'h4103_4003,
  parameter logic [31:0] DECODE_WORD = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_out,
  input  logic              wp_in,
  input  logic              ins_in
);
  localparam int TOP = SYNC_STAGES - 1;
  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLASH  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(3);

  logic [TOP:0] wp_sync, ins_sync;
  logic         ins_flag;
  logic         clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp_sync  <= '0;
      ins_sync <= '0;
    end else begin
      wp_sync  <= {wp_sync[TOP-1:0], wp_in};
      ins_sync <= {ins_sync[TOP-1:0], ins_in};
    end

  assign clr = wr_en && (addr == A_STAT) && wdata[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ins_flag <= 1'b0;
    else        ins_flag <= ins_sync[TOP] | (ins_flag & ~clr);

  assign irq_out = ins_flag;

  always_comb
    case (addr)
      A_ID:     rdata = ID_WORD;
      A_FLASH:  rdata = '0;
      A_STAT:   rdata = {28'b0, ins_flag, 2'b00, wp_sync[TOP]};
      A_DECODE: rdata = DECODE_WORD;
      default:  rdata = '0;
    endcase
endmodule

module card_id_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq_out,
  input logic              ins_seen
);
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    addr == ADDR_W'(0) |-> rdata == 32'h4103_4003); // R1
  AST_DECODE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    addr == ADDR_W'(3) |-> rdata == 32'h11); // R2
  AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    addr == ADDR_W'(2) |-> rdata[3] == irq_out); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !(wr_en && addr == ADDR_W'(2) && wdata[3])) |=> irq_out); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(2) && wdata[3] && !ins_seen) |=> !irq_out); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_seen |=> irq_out); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !irq_out); // R9
endmodule

bind card_id_regs card_id_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .irq_out(irq_out), .ins_seen(ins_sync[TOP])
);

// File: tb/card_id_regs_tb_top.sv
module card_id_regs_tb_top;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0, wp_in = 0, ins_in = 0;
  logic [31:0] wdata = '0, rdata;
  logic irq_out;
  int tests = 0, fails = 0, cyc = 0;

  card_id_regs dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .wp_in(wp_in), .ins_in(ins_in));

  always #4 clk = ~clk;

  // Behavioural reference: input history queues and a flag bit
  bit wp_q[$], ins_q[$];
  bit m_flag;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      wp_q.delete(); ins_q.delete(); m_flag = 0;
    end else begin
      bit seen;
      seen = (ins_q.size() >= 2) ? ins_q[ins_q.size()-2] : 1'b0;
      if (wr_en && addr == 2 && wdata[3]) m_flag = 0;
      if (seen) m_flag = 1;
      wp_q.push_back(wp_in); ins_q.push_back(ins_in);
      if (wp_q.size() > 4) begin void'(wp_q.pop_front()); void'(ins_q.pop_front()); end
    end
  end

  function automatic logic [31:0] exp_rd();
    bit wpv;
    wpv = (wp_q.size() >= 2) ? wp_q[wp_q.size()-2] : 1'b0;
    case (addr)
      0: return 32'h4103_4003;
      1: return 0;
      2: return {28'b0, m_flag, 2'b0, wpv};
      3: return 32'h11;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    string r;
    case (addr)
      0: r = "R1"; 1: r = "R3"; 2: r = "R4/R5/R6/R8"; 3: r = "R2"; default: r = "R10";
    endcase
    check(r, rdata, exp_rd());
    check("R7", {31'b0, irq_out}, {31'b0, m_flag});
  end

  task automatic step(logic [AW-1:0] a, logic w, logic [31:0] d, logic wp, logic ins);
    @(negedge clk); addr = a; wr_en = w; wdata = d; wp_in = wp; ins_in = ins;
  endtask

  initial begin
    ins_in = 1; wp_in = 1;
    repeat (3) @(negedge clk);
    check("R9", {31'b0, irq_out}, 0);
    addr = 2; #1 check("R9", rdata, 0);
    @(negedge clk); rst_n = 1; ins_in = 0; wp_in = 0;
    // R5 sticky after a pulse
    step(2, 0, 0, 1, 1); step(2, 0, 0, 1, 0);
    repeat (5) step(2, 0, 0, 0, 0);
    // R6 write with bit 3 clear keeps flag, bit 0 write ignored (R4)
    step(2, 1, 32'hFFFF_FFF7, 0, 0); step(2, 0, 0, 0, 0);
    step(2, 1, 32'h8, 0, 0); step(2, 0, 0, 0, 0);
    // R8 set and clear together
    step(2, 0, 0, 0, 1); step(2, 0, 0, 0, 0); step(2, 1, 32'h8, 0, 0);
    step(2, 0, 0, 0, 0); step(2, 1, 32'h8, 0, 0); step(2, 0, 0, 0, 0);
    // R3 / R10 writes ignored
    step(1, 1, 32'hFFFF_FFFF, 0, 0); step(1, 0, 0, 0, 0);
    step(9, 1, 32'hFFFF_FFFF, 0, 0); step(9, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0); step(3, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++)
      step(AW'($urandom_range(0, 6)), ($urandom_range(0, 3) == 0),
           $urandom, ($urandom_range(0, 3) == 0), ($urandom_range(0, 15) == 0));
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule